// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host processor byte access to a small internal bank of configuration registers through two I/O locations. The host first writes a register number to the index location. It then reads or writes that register through the data location, four addresses above the index location. The register number stays in place until the host changes it, so several data accesses can follow one index write.

A strap pin picks the base address of the window. With the strap low, the window sits at 0x178. With the strap high, it sits at 0x78. The bank holds:

- a configuration byte that reports the silicon revision, the strap choice and the primary-channel interrupt;
- a control byte with prefetch disables for drives 0 and 1 and the secondary-channel enable;
- seven timing bytes, one of which also carries the prefetch disables for drives 2 and 3 and the secondary-channel interrupt;
- a burst-size byte;
- a scratch byte.

Control, timing and burst values are driven out on pins for the logic that consumes them.

Top module: `cfgport_top`

## Requirements
- R1: The index location is 0x178 when `strap_alt_base` is 0 and 0x78 when it is 1. The data location is the index location plus 4. A read or write at any other address changes no state and produces no read response.
- R2: A read at either location asserts `bus_rvalid` for exactly one cycle, on the cycle after the read. `bus_rdata` carries the value in that cycle and is 0x00 whenever `bus_rvalid` is low. A read of the index location returns the register number last written.
- R3: After reset, the following hold:
  - the register number is 0x00;
  - the control, timing and scratch bytes and the writable configuration bits are 0;
  - the burst byte is 0x40;
  - `prefetch_dis` and `sec_chan_en` are 0.
- R4: Register 0x50, the configuration byte, has these bits:
  - bits 1:0 read the nonzero REVISION parameter and ignore writes;
  - bit 5 reads `strap_alt_base` and ignores writes;
  - bit 2 reads the `irq_pri` pin and ignores writes;
  - bits 7:6 and 4:3 are read/write.
- R5: Register 0x51, the control byte, is read/write. Bit 6 drives `prefetch_dis[0]`, bit 7 drives `prefetch_dis[1]`, and bit 3 drives `sec_chan_en`.
- R6: In register 0x57, bit 2 drives `prefetch_dis[2]` and bit 3 drives `prefetch_dis[3]`. Bit 4 reads the `irq_sec` pin and ignores writes. Its other bits are read/write.
- R7: Registers 0x52 to 0x58 are read/write timing bytes. Byte k of `timing_flat` (bits 8k+7:8k) holds the stored value of register 0x52+k.
- R8: Register 0x59 is the read/write burst byte, driven on `burst_size`. It resets to 0x40, which means 512 bytes.
- R9: Register 0x5B is a scratch byte that reads back the last value written to it.
- R10: Every other register number reads 0x00. Writes to such a number change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt_base | input | 1 | Base select: 0 gives 0x178, 1 gives 0x78 |
| bus_addr | input | ADDR_W (10) | Host I/O address |
| bus_wr | input | 1 | Host byte write strobe |
| bus_rd | input | 1 | Host byte read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after a decoded read |
| irq_pri | input | 1 | Primary-channel interrupt pending |
| irq_sec | input | 1 | Secondary-channel interrupt pending |
| prefetch_dis | output | 4 | Per-drive prefetch disable, drives 0 to 3 |
| sec_chan_en | output | 1 | Secondary channel enable |
| timing_flat | output | 56 | Timing bytes 0x52 to 0x58, byte k for register 0x52+k |
| burst_size | output | 8 | Burst-size byte |

## Verification
Every register is first written with all ones, or with patterns that set the read-only bit positions. The read-back values then separate stored bits from the bits that live pins and constants supply. The interrupt pins are toggled between two reads of the same register with no write in between, so a value that follows the pin cannot be mistaken for a stored one.

Timing bytes get a distinct value per register, and those values are compared against both the read port and `timing_flat`. A shifted or swapped byte shows up in that comparison.

The strap is switched, and then the old window's addresses are written and read. This shows that the decode follows the strap rather than a fixed base. Unimplemented register numbers and addresses outside the window are accessed, and the outputs are compared before and after.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef logic [7:0] byte_t;

    // Register numbers
    localparam byte_t IDX_CFG       = 8'h50;
    localparam byte_t IDX_CTRL      = 8'h51;
    localparam byte_t IDX_TIM_FIRST = 8'h52;
    localparam byte_t IDX_TIM_LAST  = 8'h58;
    localparam byte_t IDX_DRV23     = 8'h57;
    localparam byte_t IDX_BURST     = 8'h59;
    localparam byte_t IDX_SCRATCH   = 8'h5B;

    localparam int NUM_TIM = int'(IDX_TIM_LAST) - int'(IDX_TIM_FIRST) + 1;
    localparam int TIM_W   = NUM_TIM * 8;

    localparam byte_t BURST_RESET = 8'h40;

    // Configuration byte fields
    localparam int    CFG_PRI_IRQ = 2;
    localparam int    CFG_ALT_BASE = 5;
    localparam byte_t CFG_WR_MASK = 8'b1101_1000;

    // Control byte fields
    localparam int CTRL_SEC_EN = 3;
    localparam int CTRL_PF0    = 6;
    localparam int CTRL_PF1    = 7;

    // Drive 2/3 byte fields
    localparam int DRV23_PF2     = 2;
    localparam int DRV23_PF3     = 3;
    localparam int DRV23_SEC_IRQ = 4;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_INDEX = 2'd1,
        ACC_DATA  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      wr;
        logic      rd;
        byte_t     wdata;
    } bus_op_t;

    function automatic byte_t tim_index(input int k);
        return byte_t'(int'(IDX_TIM_FIRST) + k);
    endfunction

    function automatic byte_t tim_wr_mask(input int k);
        if (tim_index(k) == IDX_DRV23)
            return ~(byte_t'(1) << DRV23_SEC_IRQ);
        return 8'hFF;
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PRIMARY_BASE = 'h178,
    parameter int ALT_BASE     = 'h78,
    parameter int DATA_OFFSET  = 4
) (
    input  logic              strap_alt_base,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  byte_t             bus_wdata,
    output bus_op_t           op
);

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;

    assign idx_addr = strap_alt_base ? ADDR_W'(ALT_BASE) : ADDR_W'(PRIMARY_BASE);
    assign dat_addr = idx_addr + ADDR_W'(DATA_OFFSET);

    always_comb begin
        op.wr    = bus_wr;
        op.rd    = bus_rd;
        op.wdata = bus_wdata;
        if (bus_addr == idx_addr)
            op.kind = ACC_INDEX;
        else if (bus_addr == dat_addr)
            op.kind = ACC_DATA;
        else
            op.kind = ACC_NONE;
    end

endmodule

// File: rtl/cfgport_index.sv
module cfgport_index
    import cfgport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    output byte_t   cur_index
);

    always_ff @(posedge clk) begin
        if (rst)
            cur_index <= '0;
        else if (op.wr && op.kind == ACC_INDEX)
            cur_index <= op.wdata;
    end

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
    import cfgport_pkg::*;
#(
    parameter int REVISION = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  byte_t            idx,
    input  byte_t            wdata,
    input  logic             strap_alt_base,
    input  logic             irq_pri,
    input  logic             irq_sec,
    output byte_t            rd_value,
    output logic [3:0]       prefetch_dis,
    output logic             sec_chan_en,
    output logic [TIM_W-1:0] timing_flat,
    output byte_t            burst_size
);

    localparam byte_t REV_BITS = byte_t'(REVISION & 3);

    byte_t cfg_q;
    byte_t ctrl_q;
    byte_t burst_q;
    byte_t scratch_q;
    byte_t tim_q [NUM_TIM];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            ctrl_q    <= '0;
            burst_q   <= BURST_RESET;
            scratch_q <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_CFG:     cfg_q     <= wdata & CFG_WR_MASK;
                IDX_CTRL:    ctrl_q    <= wdata;
                IDX_BURST:   burst_q   <= wdata;
                IDX_SCRATCH: scratch_q <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_TIM; k++) begin : g_tim
        localparam byte_t MY_IDX  = tim_index(k);
        localparam byte_t MY_MASK = tim_wr_mask(k);

        always_ff @(posedge clk) begin
            if (rst)
                tim_q[k] <= '0;
            else if (wr_en && idx == MY_IDX)
                tim_q[k] <= wdata & MY_MASK;
        end

        assign timing_flat[k*8 +: 8] = tim_q[k];
    end

    localparam int DRV23_SLOT = int'(IDX_DRV23) - int'(IDX_TIM_FIRST);

    always_comb begin
        rd_value = '0;
        case (idx)
            IDX_CFG: begin
                rd_value               = (cfg_q & CFG_WR_MASK) | REV_BITS;
                rd_value[CFG_PRI_IRQ]  = irq_pri;
                rd_value[CFG_ALT_BASE] = strap_alt_base;
            end
            IDX_CTRL:    rd_value = ctrl_q;
            IDX_BURST:   rd_value = burst_q;
            IDX_SCRATCH: rd_value = scratch_q;
            default: begin
                for (int k = 0; k < NUM_TIM; k++) begin
                    if (idx == tim_index(k))
                        rd_value = tim_q[k];
                end
                if (idx == IDX_DRV23)
                    rd_value[DRV23_SEC_IRQ] = irq_sec;
            end
        endcase
    end

    assign prefetch_dis[0] = ctrl_q[CTRL_PF0];
    assign prefetch_dis[1] = ctrl_q[CTRL_PF1];
    assign prefetch_dis[2] = tim_q[DRV23_SLOT][DRV23_PF2];
    assign prefetch_dis[3] = tim_q[DRV23_SLOT][DRV23_PF3];
    assign sec_chan_en     = ctrl_q[CTRL_SEC_EN];
    assign burst_size      = burst_q;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PRIMARY_BASE = 'h178,
    parameter int ALT_BASE     = 'h78,
    parameter int DATA_OFFSET  = 4,
    parameter int REVISION     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_alt_base,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    input  logic              irq_pri,
    input  logic              irq_sec,
    output logic [3:0]        prefetch_dis,
    output logic              sec_chan_en,
    output logic [TIM_W-1:0]  timing_flat,
    output logic [7:0]        burst_size
);

    bus_op_t op;
    byte_t   cur_index;
    byte_t   rd_value;
    logic    data_wr;

    cfgport_decode #(
        .ADDR_W      (ADDR_W),
        .PRIMARY_BASE(PRIMARY_BASE),
        .ALT_BASE    (ALT_BASE),
        .DATA_OFFSET (DATA_OFFSET)
    ) u_decode (
        .strap_alt_base(strap_alt_base),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .op            (op)
    );

    cfgport_index u_index (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .cur_index(cur_index)
    );

    assign data_wr = op.wr && op.kind == ACC_DATA;

    cfgport_regfile #(
        .REVISION(REVISION)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (data_wr),
        .idx           (cur_index),
        .wdata         (op.wdata),
        .strap_alt_base(strap_alt_base),
        .irq_pri       (irq_pri),
        .irq_sec       (irq_sec),
        .rd_value      (rd_value),
        .prefetch_dis  (prefetch_dis),
        .sec_chan_en   (sec_chan_en),
        .timing_flat   (timing_flat),
        .burst_size    (burst_size)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= op.rd && op.kind != ACC_NONE;
            if (op.rd && op.kind == ACC_INDEX)
                bus_rdata <= cur_index;
            else if (op.rd && op.kind == ACC_DATA)
                bus_rdata <= rd_value;
            else
                bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
    import cfgport_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PRIMARY_BASE = 'h178,
    parameter int ALT_BASE     = 'h78,
    parameter int DATA_OFFSET  = 4,
    parameter int REVISION     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              strap_alt_base,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              bus_rvalid,
    input logic [7:0]        cur_index,
    input logic [3:0]        prefetch_dis,
    input logic              sec_chan_en,
    input logic [TIM_W-1:0]  timing_flat,
    input logic [7:0]        burst_size
);

    logic [ADDR_W-1:0] base_a;
    logic              hit_rd;
    logic              cfg_rd;

    assign base_a = strap_alt_base ? ADDR_W'(ALT_BASE) : ADDR_W'(PRIMARY_BASE);
    assign hit_rd = bus_rd && (bus_addr == base_a ||
                               bus_addr == base_a + ADDR_W'(DATA_OFFSET));
    assign cfg_rd = bus_rd && bus_addr == base_a + ADDR_W'(DATA_OFFSET) &&
                    cur_index == IDX_CFG;

    // R1
    rvalid_source_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(hit_rd));

    // R1
    read_answered_chk: assert property (@(posedge clk) disable iff (rst)
        hit_rd |=> bus_rvalid);

    // R2
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> bus_rdata == 8'h00);

    // R3
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (burst_size == BURST_RESET && prefetch_dis == 4'b0 &&
                        !sec_chan_en && cur_index == 8'h00));

    // R4
    cfg_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && $past(cfg_rd)) |->
            (bus_rdata[1:0] == 2'(REVISION) && bus_rdata[5] == $past(strap_alt_base)));

    // R5
    outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_wr)) |->
            $stable({prefetch_dis, sec_chan_en, burst_size, timing_flat}));

endmodule

bind cfgport_top cfgport_chk #(
    .ADDR_W      (ADDR_W),
    .PRIMARY_BASE(PRIMARY_BASE),
    .ALT_BASE    (ALT_BASE),
    .DATA_OFFSET (DATA_OFFSET),
    .REVISION    (REVISION)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .strap_alt_base(strap_alt_base),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .cur_index     (cur_index),
    .prefetch_dis  (prefetch_dis),
    .sec_chan_en   (sec_chan_en),
    .timing_flat   (timing_flat),
    .burst_size    (burst_size)
);

// File: tb/cfgport_top_tb.sv
module cfgport_top_tb;
    import cfgport_pkg::*;

    localparam int ADDR_W = 10;
    localparam int REV    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strap_alt_base = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              bus_rvalid;
    logic              irq_pri = 1'b0;
    logic              irq_sec = 1'b0;
    logic [3:0]        prefetch_dis;
    logic              sec_chan_en;
    logic [TIM_W-1:0]  timing_flat;
    logic [7:0]        burst_size;

    always #5 clk = ~clk;

    cfgport_top #(.ADDR_W(ADDR_W), .REVISION(REV)) u_dut (
        .clk(clk), .rst(rst), .strap_alt_base(strap_alt_base),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_pri(irq_pri), .irq_sec(irq_sec), .prefetch_dis(prefetch_dis),
        .sec_chan_en(sec_chan_en), .timing_flat(timing_flat), .burst_size(burst_size)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compares read responses against the expected queue.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R1: actual unexpected response %0h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    function automatic logic [ADDR_W-1:0] base_addr();
        return strap_alt_base ? ADDR_W'('h78) : ADDR_W'('h178);
    endfunction

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected value when a response is due.
    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic hit,
                            input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        if (hit) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        bus_write(base_addr(), idx);
        bus_write(base_addr() + ADDR_W'(4), d);
    endtask

    task automatic reg_read(input logic [7:0] idx, input logic [7:0] e, input string tag);
        bus_write(base_addr(), idx);
        bus_read(base_addr() + ADDR_W'(4), 1'b1, e, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [TIM_W-1:0] tim_exp;
        logic [TIM_W-1:0] tim_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 reset state
        check("R3 prefetch_dis", 64'(prefetch_dis), 64'h0);
        check("R3 sec_chan_en", 64'(sec_chan_en), 64'h0);
        check("R3 burst_size", 64'(burst_size), 64'h40);
        check("R3 timing_flat", 64'(timing_flat), 64'h0);
        bus_read(base_addr(), 1'b1, 8'h00, "R3 index reset");
        reg_read(8'h59, 8'h40, "R3 R8 burst reset");
        reg_read(8'h5B, 8'h00, "R3 scratch reset");
        reg_read(8'h50, 8'h02, "R4 cfg reset");

        // R4 configuration byte
        reg_write(8'h50, 8'hFF);
        reg_read(8'h50, 8'hDA, "R4 cfg all ones");
        irq_pri = 1'b1;
        reg_read(8'h50, 8'hDE, "R4 irq_pri high");
        irq_pri = 1'b0;
        reg_write(8'h50, 8'h00);
        reg_read(8'h50, 8'h02, "R4 cfg cleared");
        reg_write(8'h50, 8'hD8);

        // R7 timing bytes
        tim_exp = '0;
        for (int k = 0; k < NUM_TIM; k++) begin
            reg_write(8'h52 + 8'(k), 8'h30 + 8'(k));
            tim_exp[k*8 +: 8] = (k == 5) ? 8'h25 : 8'h30 + 8'(k);
        end
        @(negedge clk);
        check("R7 timing_flat", 64'(timing_flat), 64'(tim_exp));
        check("R6 prefetch from 0x57", 64'(prefetch_dis), 64'b0100);
        for (int k = 0; k < NUM_TIM; k++)
            reg_read(8'h52 + 8'(k), tim_exp[k*8 +: 8], "R7 timing readback");

        // R5 control byte
        reg_write(8'h51, 8'hC8);
        @(negedge clk);
        check("R5 prefetch_dis", 64'(prefetch_dis), 64'b0111);
        check("R5 sec_chan_en", 64'(sec_chan_en), 64'h1);
        reg_read(8'h51, 8'hC8, "R5 ctrl readback");
        reg_write(8'h51, 8'h40);
        @(negedge clk);
        check("R5 only drive0 disabled", 64'({prefetch_dis[1:0], sec_chan_en}), 64'b010);
        reg_write(8'h51, 8'hC8);

        // R6 drive 2/3 byte
        reg_write(8'h57, 8'hFF);
        @(negedge clk);
        check("R6 prefetch all", 64'(prefetch_dis), 64'b1111);
        check("R6 stored byte", 64'(timing_flat[5*8 +: 8]), 64'hEF);
        reg_read(8'h57, 8'hEF, "R6 irq_sec low");
        irq_sec = 1'b1;
        reg_read(8'h57, 8'hFF, "R6 irq_sec high");
        irq_sec = 1'b0;
        reg_write(8'h57, 8'h10);
        @(negedge clk);
        check("R6 write bit4 ignored", 64'(prefetch_dis), 64'b0011);
        reg_read(8'h57, 8'h00, "R6 write bit4 ignored readback");

        // R2 index readback
        bus_read(base_addr(), 1'b1, 8'h57, "R2 index readback");

        // R8 burst
        reg_write(8'h59, 8'h80);
        @(negedge clk);
        check("R8 burst_size", 64'(burst_size), 64'h80);
        reg_read(8'h59, 8'h80, "R8 burst readback");

        // R9 scratch
        reg_write(8'h5B, 8'hBD);
        reg_read(8'h5B, 8'hBD, "R9 scratch BD");
        reg_write(8'h5B, 8'h00);
        reg_read(8'h5B, 8'h00, "R9 scratch 00");

        // R10 unimplemented numbers
        tim_before = timing_flat;
        reg_write(8'h5A, 8'h55);
        reg_write(8'h00, 8'hFF);
        @(negedge clk);
        check("R10 timing unchanged", 64'(timing_flat), 64'(tim_before));
        check("R10 burst unchanged", 64'(burst_size), 64'h80);
        check("R10 ctrl outputs unchanged", 64'({prefetch_dis, sec_chan_en}), 64'b00111);
        reg_read(8'h5A, 8'h00, "R10 read 5A");
        reg_read(8'h00, 8'h00, "R10 read 00");
        reg_read(8'h60, 8'h00, "R10 read 60");

        // R1 misses at the primary base
        bus_read(ADDR_W'('h100), 1'b0, 8'h00, "R1");
        bus_read(ADDR_W'('h17A), 1'b0, 8'h00, "R1");

        // R1 alternate base
        strap_alt_base = 1'b1;
        reg_read(8'h50, 8'hFA, "R1 R4 alt base cfg");
        bus_write(ADDR_W'('h78), 8'h5B);
        bus_write(ADDR_W'('h17C), 8'h33);
        bus_write(ADDR_W'('h178), 8'h59);
        bus_read(ADDR_W'('h7C), 1'b1, 8'h00, "R1 old base write ignored");
        bus_read(ADDR_W'('h78), 1'b1, 8'h5B, "R1 old base index ignored");
        bus_read(ADDR_W'('h17C), 1'b0, 8'h00, "R1");
        check("R1 burst unchanged", 64'(burst_size), 64'h80);

        repeat (4) @(negedge clk);
        check("R2 all responses seen", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule